// File: doc/BRIEF.md
# Single-Line NMI Trigger Controller

This block watches one asynchronous non-maskable interrupt line and turns it into a clean, registered request for a parent interrupt controller. The raw line is synchronized, then qualified by one of four trigger conditions: low level, falling edge, high level or rising edge. A qualified event sets a sticky pending flag. The request output rises when that flag is set and the line is unmasked.

Software reaches three word registers over a simple 32-bit register bus. The control register holds the trigger selection and otherwise acts as plain storage. The pending register holds the flag and is cleared by writing a one. The enable register holds the mask. An elaboration parameter picks one of three address layouts, so the same block fits different register maps. The bus has no back-pressure. A transfer is a single-cycle strobe. Writes take effect at the clock edge on which `bus_en` and `bus_we` are both high. Read data is combinational from `bus_addr`.

Top module: `nmi_trig_ctrl`

## Requirements
- R1: Control bits [1:0] select the trigger: 0 = low level, 1 = falling edge, 2 = high level, 3 = rising edge.
- R2: The raw input passes through two synchronizer flops. With the line enabled and in an edge mode, `irq_out` rises on the fourth rising clock edge after a change on `nmi_in` that is set up before the first of those edges.
- R3: Pending bit 0 is cleared by writing 1 to it. Writing 0 leaves it unchanged.
- R4: In edge modes, an edge detected in the same cycle as a clear write leaves the pending flag set.
- R5: In level modes, the pending flag is set again on every cycle the active level is present, so a clear sticks only once the input is inactive.
- R6: `irq_out` is a register loaded with pending AND enable bit 0. While enable is 0, `irq_out` is 0.
- R7: Events are latched into pending while the line is masked. Setting enable afterwards raises `irq_out`.
- R8: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.
- R9: Control bits [31:2] are read/write storage. A write that changes the trigger field while keeping the upper bits reads back with the upper bits intact.
- R10: After reset, the enable register reads 0, pending reads 0 and `irq_out` is 0.
- R11: LAYOUT selects the offsets. With 0, control is at 0x00, pending at 0x04 and enable at 0x34. With 1 (the default), control is at 0x00, pending at 0x04 and enable at 0x08. With 2, control is at 0x00, enable at 0x04 and pending at 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Raw asynchronous interrupt line |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Registered request to the parent controller |

## Verification
The bench times an edge against the synchronizer and output register. A design with one flop too few or too many raises `irq_out` a cycle early or late. It lands a clear write on the exact cycle a new edge is detected; a design that gives the clear priority loses that event. It clears pending while a level is still active and expects the flag to return; a design that treated levels as edges would let the clear stick. It also drives a second instance with another layout at the same offset, which exposes any design that ignores the layout parameter or decodes unmapped offsets.

// File: rtl/nmi_trig_pkg.sv
package nmi_trig_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LO    = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HI    = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_mode_e;

  localparam int MAP_WIDE_GAP = 0;
  localparam int MAP_PEND_MID = 1;
  localparam int MAP_EN_MID   = 2;

  function automatic int unsigned ofs_ctrl(int layout);
    return 32'h00;
  endfunction

  function automatic int unsigned ofs_pend(int layout);
    return (layout == MAP_EN_MID) ? 32'h08 : 32'h04;
  endfunction

  function automatic int unsigned ofs_en(int layout);
    case (layout)
      MAP_WIDE_GAP: return 32'h34;
      MAP_EN_MID:   return 32'h04;
      default:      return 32'h08;
    endcase
  endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= RST_VAL;
          else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_detect.sv
module nmi_detect
  import nmi_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_s,
  input  trig_mode_e mode,
  input  logic       clr_pulse,
  output logic       set_evt,
  output logic       pend_bit
);
  logic prev_q;
  logic rise, fall;

  assign rise = line_s & ~prev_q;
  assign fall = ~line_s & prev_q;

  always_comb begin
    case (mode)
      TRIG_LVL_LO:    set_evt = ~line_s;
      TRIG_EDGE_FALL: set_evt = fall;
      TRIG_LVL_HI:    set_evt = line_s;
      default:        set_evt = rise;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b1;
      pend_bit <= 1'b0;
    end else begin
      prev_q   <= line_s;
      pend_bit <= set_evt | (pend_bit & ~clr_pulse);
    end
  end
endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
  import nmi_trig_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LAYOUT = MAP_PEND_MID
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              pend_bit,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] ctrl_word,
  output logic              en_bit,
  output logic              clr_pulse,
  output trig_mode_e        mode
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ofs_ctrl(LAYOUT));
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(ofs_pend(LAYOUT));
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ofs_en(LAYOUT));

  logic hit_ctrl, hit_pend, hit_en, wr;

  assign hit_ctrl = (bus_addr == A_CTRL);
  assign hit_pend = (bus_addr == A_PEND);
  assign hit_en   = (bus_addr == A_EN);
  assign wr       = bus_en & bus_we;

  assign clr_pulse = wr & hit_pend & bus_wdata[0];
  assign mode      = trig_mode_e'(ctrl_word[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_word <= '0;
      en_bit    <= 1'b0;
    end else begin
      if (wr && hit_ctrl) ctrl_word <= bus_wdata;
      if (wr && hit_en)   en_bit    <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)      bus_rdata = ctrl_word;
    else if (hit_pend) bus_rdata[0] = pend_bit;
    else if (hit_en)   bus_rdata[0] = en_bit;
  end
endmodule

// File: rtl/nmi_trig_ctrl.sv
module nmi_trig_ctrl
  import nmi_trig_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LAYOUT      = MAP_PEND_MID,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_in,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  logic       line_s;
  logic       set_evt, pend_bit, en_bit, clr_pulse;
  logic [31:0] ctrl_word;
  trig_mode_e mode;

  nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(nmi_in), .dout(line_s)
  );

  nmi_regs #(.ADDR_W(ADDR_W), .DATA_W(32), .LAYOUT(LAYOUT)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_bit(pend_bit),
    .bus_rdata(bus_rdata), .ctrl_word(ctrl_word), .en_bit(en_bit),
    .clr_pulse(clr_pulse), .mode(mode)
  );

  nmi_detect u_det (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .mode(mode),
    .clr_pulse(clr_pulse), .set_evt(set_evt), .pend_bit(pend_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= pend_bit & en_bit;
  end
endmodule

// File: rtl/nmi_trig_ctrl_chk.sv
module nmi_trig_ctrl_chk
  import nmi_trig_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LAYOUT = MAP_PEND_MID
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              irq_out,
  input logic              en_bit,
  input logic              pend_bit,
  input logic              set_evt,
  input logic              clr_pulse,
  input logic [31:0]       ctrl_word
);
  logic mapped, ctrl_wr;
  assign mapped  = (int'(bus_addr) == int'(ofs_ctrl(LAYOUT))) ||
                   (int'(bus_addr) == int'(ofs_pend(LAYOUT))) ||
                   (int'(bus_addr) == int'(ofs_en(LAYOUT)));
  assign ctrl_wr = bus_en && bus_we && (int'(bus_addr) == int'(ofs_ctrl(LAYOUT)));

  p_clear_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse && !set_evt |=> !pend_bit);
  p_pend_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_bit && !clr_pulse |=> pend_bit);
  p_edge_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend_bit);
  p_masked_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_bit |=> !irq_out);
  p_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_bit && en_bit |=> irq_out);
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == 32'h0);
  p_ctrl_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_word));
endmodule

bind nmi_trig_ctrl nmi_trig_ctrl_chk #(.ADDR_W(ADDR_W), .LAYOUT(LAYOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .en_bit(en_bit), .pend_bit(pend_bit), .set_evt(set_evt),
  .clr_pulse(clr_pulse), .ctrl_word(ctrl_word)
);

// File: tb/nmi_trig_ctrl_tb.sv
`timescale 1ns/1ps
module nmi_trig_ctrl_tb;
  localparam logic [7:0] O_CTRL = 8'h00;
  localparam logic [7:0] O_PEND = 8'h04;
  localparam logic [7:0] O_EN   = 8'h08;

  // {mode[1:0], level before, level after, expected pending}
  localparam int NVEC = 10;
  localparam logic [4:0] VEC [NVEC] = '{
    {2'd3, 1'b0, 1'b1, 1'b1},
    {2'd3, 1'b1, 1'b0, 1'b0},
    {2'd3, 1'b0, 1'b0, 1'b0},
    {2'd1, 1'b1, 1'b0, 1'b1},
    {2'd1, 1'b0, 1'b1, 1'b0},
    {2'd2, 1'b0, 1'b1, 1'b1},
    {2'd2, 1'b1, 1'b0, 1'b1},
    {2'd2, 1'b0, 1'b0, 1'b0},
    {2'd0, 1'b1, 1'b0, 1'b1},
    {2'd0, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, nmi_in = 1'b1;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_b, rdata_a;
  logic irq_b, irq_a;
  int checks = 0, failures = 0;
  logic [31:0] rv, ra;

  always #2 clk = ~clk;

  nmi_trig_ctrl #(.LAYOUT(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .irq_out(irq_b)
  );
  nmi_trig_ctrl #(.LAYOUT(0)) u_dut_a (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .irq_out(irq_a)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] db, output logic [31:0] da);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    db = rdata_b; da = rdata_a;
    bus_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic drive(logic v);
    @(negedge clk);
    nmi_in = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    // R10 reset state
    rd(O_EN, rv, ra);   chk("R10 enable", rv, 0);
    rd(O_PEND, rv, ra); chk("R10 pending", rv, 0);
    chk("R10 irq", irq_b, 0);

    // R1 trigger modes from table
    for (int i = 0; i < NVEC; i++) begin
      wr(O_CTRL, {30'd0, VEC[i][4:3]});
      drive(VEC[i][2]);
      idle(6);
      wr(O_PEND, 1);
      idle(2);
      drive(VEC[i][1]);
      idle(6);
      rd(O_PEND, rv, ra);
      chk($sformatf("R1 vec%0d", i), rv, {31'd0, VEC[i][0]});
    end

    // R9 control storage and read-modify-write
    wr(O_CTRL, 32'hA5A5_5A03);
    rd(O_CTRL, rv, ra); chk("R9 store", rv, 32'hA5A5_5A03);
    wr(O_CTRL, (rv & ~32'h3) | 32'h1);
    rd(O_CTRL, rv, ra); chk("R9 rmw", rv, 32'hA5A5_5A01);

    // R2 latency through sync and output register
    wr(O_CTRL, 32'h3);
    drive(1'b0); idle(6);
    wr(O_PEND, 1); wr(O_EN, 1); idle(2);
    chk("R2 idle", irq_b, 0);
    drive(1'b1);
    idle(3); @(negedge clk); chk("R2 edge3", irq_b, 0);
    idle(1); @(negedge clk); chk("R2 edge4", irq_b, 1);

    // R3 write-zero no effect, write-one clears
    wr(O_PEND, 0); rd(O_PEND, rv, ra); chk("R3 w0", rv, 1);
    wr(O_PEND, 1); rd(O_PEND, rv, ra); chk("R3 w1", rv, 0);
    idle(2); @(negedge clk); chk("R3 irq", irq_b, 0);

    // R4 edge coincident with clear
    drive(1'b0); idle(6);
    drive(1'b1); idle(6);
    rd(O_PEND, rv, ra); chk("R4 pre", rv, 1);
    drive(1'b0); idle(6);
    drive(1'b1);
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_addr = O_PEND; bus_wdata = 1;
    @(negedge clk); bus_en = 1'b0; bus_we = 1'b0; bus_wdata = 0;
    rd(O_PEND, rv, ra); chk("R4 coincide", rv, 1);

    // R6 masking
    wr(O_EN, 0); idle(2); @(negedge clk); chk("R6 masked", irq_b, 0);
    rd(O_PEND, rv, ra); chk("R6 pend kept", rv, 1);

    // R7 latch while masked
    wr(O_PEND, 1);
    drive(1'b0); idle(6);
    drive(1'b1); idle(6);
    @(negedge clk); chk("R7 masked", irq_b, 0);
    rd(O_PEND, rv, ra); chk("R7 latched", rv, 1);
    wr(O_EN, 1); idle(1); @(negedge clk); chk("R7 unmask", irq_b, 1);

    // R5 level persistence
    wr(O_CTRL, 32'h2); idle(4);
    wr(O_PEND, 1); rd(O_PEND, rv, ra); chk("R5 active", rv, 1);
    drive(1'b0); idle(6);
    wr(O_PEND, 1); rd(O_PEND, rv, ra); chk("R5 inactive", rv, 0);

    // R8 unmapped access
    rd(8'h10, rv, ra); chk("R8 read", rv, 0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(O_CTRL, rv, ra); chk("R8 ctrl", rv, 32'h2);
    rd(O_EN, rv, ra);   chk("R8 en", rv, 1);
    rd(O_PEND, rv, ra); chk("R8 pend", rv, 0);

    // R11 layout selection
    wr(8'h34, 1);
    rd(8'h34, rv, ra);
    chk("R11 wide en", ra, 1);
    chk("R11 default unmapped", rv, 0);
    rd(O_EN, rv, ra);
    chk("R11 default en", rv, 1);
    chk("R11 wide gap", ra, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule